// File: doc/BRIEF.md
# Single-Cycle Shift and Rotate Unit with T-Flag Path

This block performs the one-bit and fixed-distance shift operations of a 32-bit core's integer datapath. Each operation takes a 32-bit operand, the current T flag and a four-bit operation code. It produces the shifted word and the next T flag. Both are captured in output registers on the clock edge where a valid strobe is high.

The one-bit operations cover logical and arithmetic shifts, plain rotates and 33-bit rotates through T in both directions. Each of them sends the bit that leaves the word into T. The fixed logical shifts by 2, 8 and 16 bits in either direction fill with zeros and pass T through unchanged. The decoder places the result and next T on its inputs and reads both back on the following cycle.

Top module: `shift_t_unit`

## Requirements
- R1: While `rst_n` is low, `result` is zero and `t_out` is zero.
- R2: When `op_valid` is low at a clock edge, `result` and `t_out` keep their values.
- R3: Codes 0 (logical left) and 2 (arithmetic left) give operand shifted left by one with bit 0 zero, and `t_out` equals old bit 31.
- R4: Code 1 (logical right) gives operand shifted right by one with bit 31 zero, and `t_out` equals old bit 0.
- R5: Code 3 (arithmetic right) gives operand shifted right by one with bit 31 kept at its old value, and `t_out` equals old bit 0.
- R6: Code 4 (rotate left) places old bit 31 both in bit 0 and in `t_out`.
- R7: Code 5 (rotate right) places old bit 0 both in bit 31 and in `t_out`.
- R8: Code 6 (rotate left through T) shifts left, puts `t_in` in bit 0 and puts old bit 31 in `t_out`.
- R9: Code 7 (rotate right through T) shifts right, puts `t_in` in bit 31 and puts old bit 0 in `t_out`.
- R10: Codes 8, 10 and 12 shift left by 2, 8 and 16 with zero fill, and `t_out` equals `t_in`.
- R11: Codes 9, 11 and 13 shift right by 2, 8 and 16 with zero fill, and `t_out` equals `t_in`.
- R12: Codes 14 and 15 pass the operand unchanged to `result`, and `t_out` equals `t_in`.
- R13: A valid operation shows on the outputs after exactly one clock edge, so back-to-back valid operations each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Qualifies the operation in this cycle |
| op_sel | input | 4 | Operation code, see R3 to R12 |
| operand | input | 32 | Word to shift |
| t_in | input | 1 | Current T flag |
| result | output | 32 | Registered shifted word |
| t_out | output | 1 | Registered next T flag |

## Verification
In the rotates through T, one edge both injects the old T into one end of the word and captures the bit leaving the other end into T. A wrong ordering or a shared wire between the two paths would show up only when the two values differ. The bench drives every code with all-zeros, all-ones and both alternating patterns, and with both values of `t_in`. The cases where `t_in` and the outgoing bit disagree therefore occur for every code. Both `result` and `t_out` are compared against a model built from the requirements.

// File: rtl/shift_t_pkg.sv
package shift_t_pkg;

  localparam int WORD_W = 32;
  localparam int OP_W   = 4;

  // Operation codes; the low three bits select the one-bit variant,
  // bit 3 selects the fixed-distance group, bits [2:1] its distance.
  typedef enum logic [OP_W-1:0] {
    OP_LSL1  = 4'd0,
    OP_LSR1  = 4'd1,
    OP_ASL1  = 4'd2,
    OP_ASR1  = 4'd3,
    OP_ROL   = 4'd4,
    OP_ROR   = 4'd5,
    OP_RCL   = 4'd6,
    OP_RCR   = 4'd7,
    OP_LSL2  = 4'd8,
    OP_LSR2  = 4'd9,
    OP_LSL8  = 4'd10,
    OP_LSR8  = 4'd11,
    OP_LSL16 = 4'd12,
    OP_LSR16 = 4'd13,
    OP_RSV0  = 4'd14,
    OP_RSV1  = 4'd15
  } shop_e;

endpackage

// File: rtl/shift_t_rst_sync.sv
module shift_t_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/shift_t_onebit.sv
module shift_t_onebit #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         t_in,
  input  logic [2:0]   kind,
  output logic [W-1:0] dout,
  output logic         t_nx
);

  localparam int MSB = W - 1;

  logic bit_hi;
  logic bit_lo;

  assign bit_hi = din[MSB];
  assign bit_lo = din[0];

  always_comb begin
    dout = din;
    t_nx = t_in;
    unique case (kind)
      3'd0, 3'd2: begin
        dout = {din[MSB-1:0], 1'b0};
        t_nx = bit_hi;
      end
      3'd1: begin
        dout = {1'b0, din[MSB:1]};
        t_nx = bit_lo;
      end
      3'd3: begin
        dout = {bit_hi, din[MSB:1]};
        t_nx = bit_lo;
      end
      3'd4: begin
        dout = {din[MSB-1:0], bit_hi};
        t_nx = bit_hi;
      end
      3'd5: begin
        dout = {bit_lo, din[MSB:1]};
        t_nx = bit_lo;
      end
      3'd6: begin
        dout = {din[MSB-1:0], t_in};
        t_nx = bit_hi;
      end
      3'd7: begin
        dout = {t_in, din[MSB:1]};
        t_nx = bit_lo;
      end
      default: begin
        dout = din;
        t_nx = t_in;
      end
    endcase
  end

endmodule

// File: rtl/shift_t_fixed.sv
module shift_t_fixed #(
  parameter int W    = 32,
  parameter int AMT0 = 2,
  parameter int AMT1 = 8,
  parameter int AMT2 = 16
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   dist_sel,
  input  logic         to_right,
  output logic [W-1:0] dout
);

  localparam int NDIST = 3;

  logic [W-1:0] left_v  [NDIST];
  logic [W-1:0] right_v [NDIST];

  for (genvar g = 0; g < NDIST; g++) begin : g_dist
    localparam int AMT = (g == 0) ? AMT0 : ((g == 1) ? AMT1 : AMT2);
    assign left_v[g]  = {din[W-1-AMT:0], {AMT{1'b0}}};
    assign right_v[g] = {{AMT{1'b0}}, din[W-1:AMT]};
  end

  always_comb begin
    dout = din;
    if (dist_sel < 2'(NDIST)) begin
      dout = to_right ? right_v[dist_sel] : left_v[dist_sel];
    end
  end

endmodule

// File: rtl/shift_t_unit.sv
module shift_t_unit
  import shift_t_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int FIX_A  = 2,
  parameter int FIX_B  = 8,
  parameter int FIX_C  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] operand,
  input  logic              t_in,
  output logic [DATA_W-1:0] result,
  output logic              t_out
);

  localparam int SYNC_STAGES = 2;

  logic              rst_sync_n;
  logic [DATA_W-1:0] ob_res;
  logic              ob_t;
  logic [DATA_W-1:0] fx_res;
  logic              grp_fixed;
  logic              grp_rsv;

  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] res_nx;
  logic              t_q;
  logic              t_nx;
  logic              load_en;

  shift_t_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  shift_t_onebit #(.W(DATA_W)) u_onebit (
    .din  (operand),
    .t_in (t_in),
    .kind (op_sel[2:0]),
    .dout (ob_res),
    .t_nx (ob_t)
  );

  shift_t_fixed #(
    .W    (DATA_W),
    .AMT0 (FIX_A),
    .AMT1 (FIX_B),
    .AMT2 (FIX_C)
  ) u_fixed (
    .din      (operand),
    .dist_sel (op_sel[2:1]),
    .to_right (op_sel[0]),
    .dout     (fx_res)
  );

  assign grp_fixed = op_sel[3];
  assign grp_rsv   = op_sel[3] & (op_sel[2:1] == 2'b11);
  assign load_en   = op_valid;

  // next-state selection
  always_comb begin
    res_nx = res_q;
    t_nx   = t_q;
    if (load_en) begin
      if (!grp_fixed) begin
        res_nx = ob_res;
        t_nx   = ob_t;
      end else if (!grp_rsv) begin
        res_nx = fx_res;
        t_nx   = t_in;
      end else begin
        res_nx = operand;
        t_nx   = t_in;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      t_q   <= 1'b0;
    end else if (load_en) begin
      res_q <= res_nx;
      t_q   <= t_nx;
    end
  end

  assign result = res_q;
  assign t_out  = t_q;

endmodule

// File: rtl/shift_t_unit_chk.sv
module shift_t_unit_chk #(
  parameter int DATA_W = 32,
  parameter int OPW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [OPW-1:0]    op_sel,
  input logic [DATA_W-1:0] operand,
  input logic              t_in,
  input logic [DATA_W-1:0] result,
  input logic              t_out
);

  // counts edges since reset so $past never reaches the sync window
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  assign warm = (age_q == 2'd3);

  always_comb begin
    if (rst_n === 1'b0) begin
      a_reset_r1: assert (result == '0 && t_out == 1'b0);
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(op_valid)) |-> ($stable(result) && $stable(t_out)));

  p_rol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(op_valid) && $past(op_sel) == 4'd4) |->
      (result[0] == $past(operand[DATA_W-1]) && t_out == $past(operand[DATA_W-1])));

  p_rcl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(op_valid) && $past(op_sel) == 4'd6) |->
      (result[0] == $past(t_in) && t_out == $past(operand[DATA_W-1])));

  p_rcr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(op_valid) && $past(op_sel) == 4'd7) |->
      (result[DATA_W-1] == $past(t_in) && t_out == $past(operand[0])));

  p_sar_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(op_valid) && $past(op_sel) == 4'd3) |->
      (result[DATA_W-1] == result[DATA_W-2]));

  p_fixed_t_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(op_valid) && $past(op_sel[3])) |-> (t_out == $past(t_in)));

endmodule

bind shift_t_unit shift_t_unit_chk #(.DATA_W(DATA_W), .OPW(shift_t_pkg::OP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_sel   (op_sel),
  .operand  (operand),
  .t_in     (t_in),
  .result   (result),
  .t_out    (t_out)
);

// File: tb/shift_t_unit_tb.sv
module shift_t_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [31:0] operand;
  logic        t_in;
  logic [31:0] result;
  logic        t_out;

  int checks;
  int errors;

  shift_t_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .operand  (operand),
    .t_in     (t_in),
    .result   (result),
    .t_out    (t_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pats [6];
  initial begin
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hAAAA_AAAA;
    pats[3] = 32'h5555_5555;
    pats[4] = 32'h8000_0001;
    pats[5] = 32'h1234_5678;
  end

  function automatic string req_of(input int op);
    case (op)
      0, 2: return "R3";
      1: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      8, 10, 12: return "R10";
      9, 11, 13: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input int op, input logic [31:0] d, input logic t,
                       output logic [31:0] r, output logic tn);
    tn = t;
    case (op)
      0, 2: begin r = d << 1; tn = d[31]; end
      1: begin r = d >> 1; tn = d[0]; end
      3: begin r = 32'($signed(d) >>> 1); tn = d[0]; end
      4: begin r = (d << 1) | (d >> 31); tn = d[31]; end
      5: begin r = (d >> 1) | (d << 31); tn = d[0]; end
      6: begin r = (d << 1) | {31'd0, t}; tn = d[31]; end
      7: begin r = (d >> 1) | {t, 31'd0}; tn = d[0]; end
      8:  r = d << 2;
      9:  r = d >> 2;
      10: r = d << 8;
      11: r = d >> 8;
      12: r = d << 16;
      13: r = d >> 16;
      default: r = d;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] exp_r, input logic exp_t);
    checks++;
    if (result !== exp_r || t_out !== exp_t) begin
      errors++;
      $display("FAIL %s: result=%h t=%b expected result=%h t=%b",
               req, result, t_out, exp_r, exp_t);
    end
  endtask

  task automatic issue(input int op, input logic [31:0] d, input logic t);
    @(negedge clk);
    op_valid = 1'b1;
    op_sel   = 4'(op);
    operand  = d;
    t_in     = t;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_valid = 1'b0;
    op_sel = '0;
    operand = '0;
    t_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 1'b0);
    operand = 32'hFFFF_FFFF;
    t_in = 1'b1;
    op_valid = 1'b1;
    @(negedge clk);
    check("R1", 32'h0, 1'b0);
    op_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 32'h0, 1'b0);
  endtask

  task automatic t_sweep;
    logic [31:0] er;
    logic et;
    for (int op = 0; op < 16; op++) begin
      for (int p = 0; p < 6; p++) begin
        for (int tv = 0; tv < 2; tv++) begin
          issue(op, pats[p], tv[0]);
          model(op, pats[p], tv[0], er, et);
          check(req_of(op), er, et);
        end
      end
    end
  endtask

  task automatic t_hold;
    logic [31:0] er;
    logic et;
    issue(7, 32'h8000_0001, 1'b0);
    model(7, 32'h8000_0001, 1'b0, er, et);
    check("R9", er, et);
    op_sel = 4'd4;
    operand = 32'h0F0F_0F0F;
    t_in = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2", er, et);
    end
  endtask

  task automatic t_back2back;
    logic [31:0] er;
    logic et;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      op_valid = 1'b1;
      op_sel   = (i % 2 == 0) ? 4'd6 : 4'd11;
      operand  = pats[i];
      t_in     = i[0];
      model(int'(op_sel), pats[i], i[0], er, et);
      @(negedge clk);
      check("R13", er, et);
    end
    op_valid = 1'b0;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_sweep();
    t_hold();
    t_back2back();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule